// File: doc/BRIEF.md
# Combinable Register Operate Unit

This block carries out the register-group instructions of a 17-bit accumulator machine. It holds two 17-bit working registers (A and B), a carry flag and a greater-than flag. It takes one instruction word per accepted cycle. Every register-group word names one target register and carries a set of micro-operation bits. Several of those bits may be set together, and they then act in a fixed order within the same cycle. The block writes the new register and flag values and gives a one-cycle skip decision that the sequencer uses to step over the next instruction.

Bits are named B17 (most significant, the sign bit) down to B1. The top five bits B17:B13 must be zero for a word to be handled here. B12:B11 pick the group, B10 picks the target (1 = A, 0 = B), and B9:B1 hold the micro-operation field. Shifts and rotates act only on the 16-bit magnitude B16:B1. Multi-place forms finish in a single cycle through a logarithmic barrel network. The switch-register value is an input that one micro-operation copies into the target.

Top module: `rop_unit`

## Requirements
- R1: A word with B10=1 writes only A, and a word with B10=0 writes only B. The register that is not named keeps its value.
- R2: Single-place shifts and rotates (group B12:B11=01, B7 = shift, B6 = rotate, B8 = left) act on B16:B1 only, and B17 keeps its value. A plain shift fills the vacated bit with 0, and carry is unchanged unless B5 is set.
- R3: With B5 set in group 01, a rotate runs through a 17-bit ring made of carry and B16:B1, and a shift sends the bit shifted out into carry.
- R4: Group 00 with B9=1 shifts B16:B1 by n = B4:B1 places in one cycle. B8:B7 select the kind: 00 rotate right, 01 shift right, 10 rotate left, 11 shift left. B17 and carry are unchanged.
- R5: In the group-00 shift-right form, B5 set makes the shift arithmetic: B16 is copied into every vacated position.
- R6: Group 01 tests the value as it was before the word acted on it: B1 skips if B1 is 0, and B2 skips if B16 is 0. B9 then clears carry, B3 increments and B4 decrements, both modulo 2^17. Any shift or rotate acts last.
- R7: Group 10 changes the target in this order: clear (B9), load switches (B1), one's complement (B8), clear B17 (B3), complement B17 (B2), swap B16:B9 with B8:B1 (B4).
- R8: In group 10, B5 skips unconditionally, B7 clears carry and B6 then complements carry.
- R9: Group 11 selects tests with B8 (B17), B7 (nonzero), B6 (carry) and B4 (greater-than). With B9=1 it skips if any selected item is set or nonzero. With B9=0 it skips if at least one test is selected and every selected item is clear or zero.
- R10: Group 11 tests the original value. It then clears the target (B2), complements it (B1), clears carry (B5) and clears greater-than (B3).
- R11: The word 001001 (octal) sets the greater-than flag and changes nothing else.
- R12: A word with B17:B13 nonzero, a group-00 word with B10 and B9 both 0, or a cycle with the valid input low leaves all registers and flags unchanged and gives no skip.
- R13: After reset, the registers, flags and skip are all 0. The skip output is high for exactly the one cycle after the word that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 17 | Instruction word, bit 16 = B17 |
| switches | input | 17 | Switch-register value |
| a_reg | output | 17 | Register A |
| b_reg | output | 17 | Register B |
| carry | output | 1 | Carry flag |
| gt | output | 1 | Greater-than flag |
| skip | output | 1 | Skip-next pulse |

## Verification
The bench targets the boundaries of the magnitude field. A rotate that wrapped through B17 would change the sign bit, and a plain shift that filled from carry would leave a stray 1. It checks that carry gets the exiting bit only in the through-carry forms, that a 15-place shift and a 4-place arithmetic shift give exact patterns, and that increment and decrement wrap at 2^17. For combined words it checks the ordering: a design that cleared before testing would skip wrongly on 007502, and one that complemented the sign before clearing it would not set B17 on 005006. It also checks both senses of the skip inversion and words from other instruction groups, which must leave the state alone.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int WORD_W = 17;
  localparam int MAG_W  = WORD_W - 1;
  localparam int BYTE_W = MAG_W / 2;
  localparam int OPS_W  = 9;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_MULTI,
    CL_SETGT,
    CL_G1,
    CL_G2,
    CL_G3
  } rop_class_e;

  typedef enum logic [1:0] {
    SH_ROT,
    SH_LOG,
    SH_ARI
  } shift_mode_e;

  typedef struct packed {
    rop_class_e       cls;
    logic             sel_a;
    logic [OPS_W-1:0] ops;
  } rop_dec_t;
endpackage

// File: rtl/rop_shifter.sv
module rop_shifter
  import rop_pkg::*;
#(
  parameter int DW = MAG_W,
  parameter int AW = CNT_W
) (
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] amt,
  input  logic          left,
  input  shift_mode_e   mode,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] fill;

  assign fill = (mode == SH_ARI) ? {DW{din[DW-1]}} : '0;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [DW-1:0] di;
    logic [DW-1:0] lv;
    logic [DW-1:0] rv;
    logic [DW-1:0] q;

    if (s == 0) begin : g_first
      assign di = din;
    end else begin : g_next
      assign di = g_stage[s-1].q;
    end

    if (K < DW) begin : g_part
      always_comb begin
        if (mode == SH_ROT) begin
          lv = {di[DW-1-K:0], di[DW-1:DW-K]};
          rv = {di[K-1:0], di[DW-1:K]};
        end else begin
          lv = {di[DW-1-K:0], {K{1'b0}}};
          rv = {fill[K-1:0], di[DW-1:K]};
        end
      end
    end else begin : g_full
      always_comb begin
        lv = (mode == SH_ROT) ? di : '0;
        rv = (mode == SH_ROT) ? di : fill;
      end
    end

    assign q = amt[s] ? (left ? lv : rv) : di;
  end

  assign dout = g_stage[AW-1].q;
endmodule

// File: rtl/rop_decode.sv
module rop_decode
  import rop_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output rop_dec_t          dec
);
  localparam int GRP_LO = OPS_W + 1;
  localparam int TOP_LO = GRP_LO + 2;

  logic [WORD_W-TOP_LO-1:0] top_bits;
  logic [1:0]               grp;

  assign top_bits = word[WORD_W-1:TOP_LO];
  assign grp      = word[TOP_LO-1:GRP_LO];

  always_comb begin
    dec.sel_a = word[OPS_W];
    dec.ops   = word[OPS_W-1:0];
    dec.cls   = CL_NONE;
    if (top_bits == '0) begin
      unique case (grp)
        2'b00: begin
          if (word[OPS_W-1])
            dec.cls = CL_MULTI;
          else if (word[OPS_W] && word[0])
            dec.cls = CL_SETGT;
          else
            dec.cls = CL_NONE;
        end
        2'b01:   dec.cls = CL_G1;
        2'b10:   dec.cls = CL_G2;
        default: dec.cls = CL_G3;
      endcase
    end
  end
endmodule

// File: rtl/rop_exec.sv
module rop_exec
  import rop_pkg::*;
(
  input  rop_dec_t          dec,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              c_i,
  input  logic              gt_i,
  input  logic [WORD_W-1:0] sw_i,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o,
  output logic              c_o,
  output logic              gt_o,
  output logic              skip_o
);
  logic [WORD_W-1:0] r;
  logic [WORD_W-1:0] g1_v;
  logic [MAG_W-1:0]  sh_in;
  logic [MAG_W-1:0]  sh_out;
  logic [CNT_W-1:0]  sh_amt;
  logic              sh_left;
  shift_mode_e       sh_mode;
  logic [WORD_W-1:0] rn;
  logic              wr;
  logic [OPS_W-1:0]  op;

  assign op   = dec.ops;
  assign r    = dec.sel_a ? a_i : b_i;
  assign g1_v = r + WORD_W'(op[2]) - WORD_W'(op[3]);

  // shifter control: multi-place forms versus single-place group-one forms
  always_comb begin
    if (dec.cls == CL_MULTI) begin
      sh_in   = r[MAG_W-1:0];
      sh_amt  = op[CNT_W-1:0];
      sh_left = op[7];
      if (!op[6])
        sh_mode = SH_ROT;
      else if (!op[7] && op[4])
        sh_mode = SH_ARI;
      else
        sh_mode = SH_LOG;
    end else begin
      sh_in   = g1_v[MAG_W-1:0];
      sh_amt  = CNT_W'(1);
      sh_left = op[7];
      sh_mode = (op[5] && !op[6]) ? SH_ROT : SH_LOG;
    end
  end

  rop_shifter #(.DW(MAG_W), .AW(CNT_W)) u_shift (
    .din  (sh_in),
    .amt  (sh_amt),
    .left (sh_left),
    .mode (sh_mode),
    .dout (sh_out)
  );

  always_comb begin
    logic              c_tmp;
    logic              rot;
    logic [MAG_W-1:0]  body;
    logic [WORD_W-1:0] v;
    logic [3:0]        sel;
    logic [3:0]        cond;
    logic              hit;

    rn     = r;
    wr     = 1'b0;
    c_o    = c_i;
    gt_o   = gt_i;
    skip_o = 1'b0;
    c_tmp  = c_i;
    rot    = 1'b0;
    body   = '0;
    v      = r;
    sel    = '0;
    cond   = '0;
    hit    = 1'b0;

    unique case (dec.cls)
      CL_MULTI: begin
        wr = 1'b1;
        rn = {r[WORD_W-1], sh_out};
      end

      CL_SETGT: begin
        gt_o = 1'b1;
      end

      CL_G1: begin
        wr     = 1'b1;
        skip_o = (op[0] && !r[0]) || (op[1] && !r[MAG_W-1]);
        c_tmp  = op[8] ? 1'b0 : c_i;
        rot    = op[5] && !op[6];
        body   = g1_v[MAG_W-1:0];
        if (op[5] || op[6]) begin
          if (op[4]) begin
            if (op[7]) begin
              c_tmp = g1_v[MAG_W-1];
              body  = {g1_v[MAG_W-2:0], rot ? c_o_src(op[8], c_i) : 1'b0};
            end else begin
              c_tmp = g1_v[0];
              body  = {rot ? c_o_src(op[8], c_i) : 1'b0, g1_v[MAG_W-1:1]};
            end
          end else begin
            body = sh_out;
          end
        end
        c_o = c_tmp;
        rn  = {g1_v[WORD_W-1], body};
      end

      CL_G2: begin
        wr = 1'b1;
        v  = op[8] ? '0 : r;
        if (op[0]) v = sw_i;
        if (op[7]) v = ~v;
        if (op[2]) v[WORD_W-1] = 1'b0;
        if (op[1]) v[WORD_W-1] = ~v[WORD_W-1];
        if (op[3]) v = {v[WORD_W-1], v[BYTE_W-1:0], v[MAG_W-1:BYTE_W]};
        rn     = v;
        c_tmp  = op[6] ? 1'b0 : c_i;
        c_o    = op[5] ? ~c_tmp : c_tmp;
        skip_o = op[4];
      end

      CL_G3: begin
        wr   = 1'b1;
        sel  = {op[7], op[6], op[5], op[3]};
        cond = {r[WORD_W-1], |r, c_i, gt_i};
        hit  = |(sel & cond);
        skip_o = op[8] ? hit : ((|sel) && !hit);
        v  = op[1] ? '0 : r;
        if (op[0]) v = ~v;
        rn   = v;
        c_o  = op[4] ? 1'b0 : c_i;
        gt_o = op[2] ? 1'b0 : gt_i;
      end

      default: ;
    endcase
  end

  // carry value seen by a through-carry rotate after the optional clear
  function automatic logic c_o_src(input logic clr, input logic c);
    return clr ? 1'b0 : c;
  endfunction

  assign a_o = (wr && dec.sel_a)  ? rn : a_i;
  assign b_o = (wr && !dec.sel_a) ? rn : b_i;
endmodule

// File: rtl/rop_unit.sv
module rop_unit
  import rop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] switches,
  output logic [WORD_W-1:0] a_reg,
  output logic [WORD_W-1:0] b_reg,
  output logic              carry,
  output logic              gt,
  output logic              skip
);
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_int_n = rsync_q[SYNC_STAGES-1];

  rop_dec_t          dec;
  logic [WORD_W-1:0] a_q, b_q, a_nx, b_nx, a_d, b_d;
  logic              c_q, g_q, s_q, c_nx, g_nx, s_nx, c_d, g_d, s_d;

  rop_decode u_dec (
    .word (instr),
    .dec  (dec)
  );

  rop_exec u_exec (
    .dec    (dec),
    .a_i    (a_q),
    .b_i    (b_q),
    .c_i    (c_q),
    .gt_i   (g_q),
    .sw_i   (switches),
    .a_o    (a_nx),
    .b_o    (b_nx),
    .c_o    (c_nx),
    .gt_o   (g_nx),
    .skip_o (s_nx)
  );

  // next-state selection under the clock enable
  always_comb begin
    a_d = instr_valid ? a_nx : a_q;
    b_d = instr_valid ? b_nx : b_q;
    c_d = instr_valid ? c_nx : c_q;
    g_d = instr_valid ? g_nx : g_q;
    s_d = instr_valid && s_nx;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
      g_q <= 1'b0;
      s_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
      g_q <= g_d;
      s_q <= s_d;
    end
  end

  assign a_reg = a_q;
  assign b_reg = b_q;
  assign carry = c_q;
  assign gt    = g_q;
  assign skip  = s_q;
endmodule

// File: rtl/rop_unit_chk.sv
module rop_unit_chk
  import rop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] a_reg,
  input logic [WORD_W-1:0] b_reg,
  input logic              carry,
  input logic              gt,
  input logic              skip
);
  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R13
  skip_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (started && $past(instr_valid)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(instr_valid)) |->
      ($stable(a_reg) && $stable(b_reg) && $stable(carry) && $stable(gt) && !skip));

  // R12
  foreign_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && instr_valid && (instr[16:12] != 5'd0)) |=>
      ($stable(a_reg) && $stable(b_reg) && $stable(carry) && $stable(gt) && !skip));

  // R1
  a_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && instr_valid && instr[16:12] == 5'd0 && instr[11:10] != 2'b00 && !instr[9])
      |=> $stable(a_reg));

  // R1
  b_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && instr_valid && instr[16:12] == 5'd0 && instr[11:10] != 2'b00 && instr[9])
      |=> $stable(b_reg));

  // R2
  sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && instr_valid && instr[16:9] == 8'b00000_011 && instr[3:2] == 2'b00)
      |=> (a_reg[16] == $past(a_reg[16])));

  // R4
  multi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && instr_valid && instr[16:10] == 7'd0 && instr[8]) |=> $stable(carry));

  // R11
  set_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && instr_valid && instr == 17'o001001) |=> gt);

  // R8
  uncond_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && instr_valid && instr[16:10] == 7'b00000_10 && instr[4]) |=> skip);
endmodule

bind rop_unit rop_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .a_reg       (a_reg),
  .b_reg       (b_reg),
  .carry       (carry),
  .gt          (gt),
  .skip        (skip)
);

// File: tb/tb_rop_unit.sv
module tb_rop_unit;
  logic        clk;
  logic        rst_n;
  logic        valid;
  logic [16:0] instr;
  logic [16:0] sw;
  logic [16:0] a_reg, b_reg;
  logic        carry, gt, skip;

  int checks;
  int errors;
  bit finished;

  logic [16:0] qa[$];
  logic [16:0] qb[$];
  logic [2:0]  qf[$];
  string       qt[$];

  rop_unit dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (valid),
    .instr       (instr),
    .switches    (sw),
    .a_reg       (a_reg),
    .b_reg       (b_reg),
    .carry       (carry),
    .gt          (gt),
    .skip        (skip)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%o expected=%o", tag, what, act, exp);
    end
  endtask

  // driver: present one word and queue the state expected after it
  task automatic issue(input logic [16:0] w, input logic [16:0] s,
                       input logic [16:0] ea, input logic [16:0] eb,
                       input logic ec, input logic eg, input logic es,
                       input string tag);
    @(negedge clk);
    instr = w;
    sw    = s;
    valid = 1'b1;
    qa.push_back(ea);
    qb.push_back(eb);
    qf.push_back({ec, eg, es});
    qt.push_back(tag);
    @(negedge clk);
    valid = 1'b0;
  endtask

  // monitor: compare after the edge that accepted a word
  always @(posedge clk) begin
    if (rst_n && valid) begin
      logic [16:0] ea, eb;
      logic [2:0]  ef;
      string       t;
      #5;
      ea = qa.pop_front();
      eb = qb.pop_front();
      ef = qf.pop_front();
      t  = qt.pop_front();
      check(a_reg === ea, t, "a_reg", a_reg, ea);
      check(b_reg === eb, t, "b_reg", b_reg, eb);
      check(carry === ef[2], t, "carry", {16'd0, carry}, {16'd0, ef[2]});
      check(gt === ef[1], t, "gt", {16'd0, gt}, {16'd0, ef[1]});
      check(skip === ef[0], t, "skip", {16'd0, skip}, {16'd0, ef[0]});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R13 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    valid = 1'b0;
    instr = '0;
    sw    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    check(a_reg === 17'o0, "R13", "reset a_reg", a_reg, 17'o0);
    check(b_reg === 17'o0, "R13", "reset b_reg", b_reg, 17'o0);
    check({carry, gt, skip} === 3'b000, "R13", "reset flags", {14'd0, carry, gt, skip}, 17'o0);

    issue(17'o005001, 17'o300001, 17'o300001, 17'o000000, 0, 0, 0, "R7 load A");
    issue(17'o004001, 17'o000001, 17'o300001, 17'o000001, 0, 0, 0, "R1 load B");
    issue(17'o003300, 17'o0, 17'o200002, 17'o000001, 0, 0, 0, "R2 shift left");
    issue(17'o003040, 17'o0, 17'o200001, 17'o000001, 0, 0, 0, "R2 rotate right");
    issue(17'o003040, 17'o0, 17'o300000, 17'o000001, 0, 0, 0, "R2 rotate wrap");
    issue(17'o003260, 17'o0, 17'o200000, 17'o000001, 1, 0, 0, "R3 rotate left carry");
    issue(17'o003060, 17'o0, 17'o300000, 17'o000001, 0, 0, 0, "R3 rotate right carry");
    issue(17'o003320, 17'o0, 17'o200000, 17'o000001, 1, 0, 0, "R3 shift into carry");
    issue(17'o002400, 17'o0, 17'o200000, 17'o000001, 0, 0, 0, "R6 clear carry");
    issue(17'o000717, 17'o0, 17'o200000, 17'o100000, 0, 0, 0, "R4 shift left 15");
    issue(17'o005001, 17'o100001, 17'o100001, 17'o100000, 0, 0, 0, "R7 load A");
    issue(17'o001403, 17'o0, 17'o030000, 17'o100000, 0, 0, 0, "R4 rotate right 3");
    issue(17'o005001, 17'o100001, 17'o100001, 17'o100000, 0, 0, 0, "R7 load A");
    issue(17'o001517, 17'o0, 17'o000001, 17'o100000, 0, 0, 0, "R4 shift right 15");
    issue(17'o005001, 17'o300001, 17'o300001, 17'o100000, 0, 0, 0, "R7 load A");
    issue(17'o001524, 17'o0, 17'o374000, 17'o100000, 0, 0, 0, "R5 arith right 4");
    issue(17'o005001, 17'o377777, 17'o377777, 17'o100000, 0, 0, 0, "R7 load A");
    issue(17'o003005, 17'o0, 17'o000000, 17'o100000, 0, 0, 0, "R6 inc wrap no skip");
    issue(17'o003001, 17'o0, 17'o000000, 17'o100000, 0, 0, 1, "R6 skip B1 zero");
    issue(17'o003012, 17'o0, 17'o377777, 17'o100000, 0, 0, 1, "R6 dec wrap skip B16 zero");
    issue(17'o005400, 17'o0, 17'o000000, 17'o100000, 0, 0, 0, "R7 clear");
    issue(17'o005006, 17'o0, 17'o200000, 17'o100000, 0, 0, 0, "R7 clear then comp sign");
    issue(17'o007600, 17'o0, 17'o200000, 17'o100000, 0, 0, 1, "R9 skip negative");
    issue(17'o007200, 17'o0, 17'o200000, 17'o100000, 0, 0, 0, "R9 skip positive");
    issue(17'o005001, 17'o200377, 17'o200377, 17'o100000, 0, 0, 0, "R7 load A");
    issue(17'o005010, 17'o0, 17'o377400, 17'o100000, 0, 0, 0, "R7 byte swap");
    issue(17'o005201, 17'o000017, 17'o377760, 17'o100000, 0, 0, 0, "R7 load then complement");
    issue(17'o005020, 17'o0, 17'o377760, 17'o100000, 0, 0, 1, "R8 unconditional skip");
    issue(17'o004140, 17'o0, 17'o377760, 17'o100000, 1, 0, 0, "R8 clear then comp carry");
    issue(17'o006440, 17'o0, 17'o377760, 17'o100000, 1, 0, 1, "R9 skip carry set");
    issue(17'o006040, 17'o0, 17'o377760, 17'o100000, 1, 0, 0, "R9 skip carry clear");
    issue(17'o001001, 17'o0, 17'o377760, 17'o100000, 1, 1, 0, "R11 set gt");
    issue(17'o006410, 17'o0, 17'o377760, 17'o100000, 1, 1, 1, "R9 skip gt");
    issue(17'o006004, 17'o0, 17'o377760, 17'o100000, 1, 0, 0, "R10 clear gt");
    issue(17'o007002, 17'o0, 17'o000000, 17'o100000, 1, 0, 0, "R10 clear A");
    issue(17'o007100, 17'o0, 17'o000000, 17'o100000, 1, 0, 1, "R9 skip zero");
    issue(17'o007500, 17'o0, 17'o000000, 17'o100000, 1, 0, 0, "R9 skip nonzero");
    issue(17'o005001, 17'o000005, 17'o000005, 17'o100000, 1, 0, 0, "R7 load A");
    issue(17'o007502, 17'o0, 17'o000000, 17'o100000, 1, 0, 1, "R10 test then clear");
    issue(17'o007003, 17'o0, 17'o377777, 17'o100000, 1, 0, 0, "R10 clear then complement");
    issue(17'o007300, 17'o0, 17'o377777, 17'o100000, 1, 0, 0, "R9 false sense combined");
    issue(17'o007020, 17'o0, 17'o377777, 17'o100000, 0, 0, 0, "R10 clear carry");
    issue(17'o006002, 17'o0, 17'o377777, 17'o000000, 0, 0, 0, "R1 clear B only");
    issue(17'o025000, 17'o0, 17'o377777, 17'o000000, 0, 0, 0, "R12 foreign word");
    issue(17'o000001, 17'o0, 17'o377777, 17'o000000, 0, 0, 0, "R12 group zero unused");
    issue(17'o005020, 17'o0, 17'o377777, 17'o000000, 0, 0, 1, "R8 skip before idle");

    // R12 and R13: valid low with a clearing word, skip must have dropped
    @(negedge clk);
    instr = 17'o007002;
    valid = 1'b0;
    @(negedge clk);
    check(a_reg === 17'o377777, "R12", "idle a_reg", a_reg, 17'o377777);
    check(skip === 1'b0, "R13", "skip one cycle", {16'd0, skip}, 17'o0);
    check(qa.size() == 0, "R13", "scoreboard drained", 17'(qa.size()), 17'o0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule